// File: doc/BRIEF.md
# Paged receive ring writer

This block takes an incoming byte stream of frames and stores each frame in a circular receive buffer made of 256-byte pages. The ring covers the pages from a programmable first page up to, but not including, a programmable limit page. A byte's address is its page number times 256 plus its offset in the page. Frame data starts four bytes into the current page, which leaves room for a header. Once the last byte has been stored, the block writes that four-byte header at offset 0 of the page. One cycle later it moves the current-page register to the first free page after the frame.

The host consumes frames from the ring. It returns pages by moving a boundary page register, and the writer never stores a byte in the boundary page. A frame that would enter that page is abandoned and a warning pulse is raised. In that case the current-page register keeps its old value, so the partial frame is never visible to the host. In monitor mode no frame is stored, and every frame produces a missed-frame pulse instead.

Top module: `rxring_writer`

## Requirements
- R1: The first byte of an accepted frame is written at address curPage*256+4, and every further byte goes to the next address. A byte accepted on a clock edge appears as a one-cycle memWe strobe right after that edge.
- R2: After offset 255 of page ringStop-1, the next data byte is written at offset 0 of page ringStart. After offset 255 of any other page, it goes to offset 0 of the following page.
- R3: In the four cycles after the last data byte's write, the header is written to curPage*256+0..3, one byte per cycle, in this order: status, next page, length bits 7:0, length bits 15:8. The length counts every byte of the frame, including its CRC bytes.
- R4: The status byte has these bits:
  - bit 0 is set when neither the CRC nor the alignment error flag is set;
  - bit 1 is the CRC error flag;
  - bit 2 is the alignment error flag;
  - bit 5 is the multicast/physical flag;
  - bits 3, 4, 6 and 7 are 0.
  All flags are sampled with the last byte.
- R5: The next-page value is the page after the page that holds the frame's last byte, wrapping from ringStop-1 to ringStart. This equals curPage + ceil((length+4)/256), modulo the ring span.
- R6: curPage takes the next-page value on the cycle after the last header write. curLoad loads curLoadVal on the edge where it is sampled.
- R7: If a frame starts while curPage equals boundary, ovwPulse is raised once, nothing is written, and curPage keeps its value.
- R8: If a data byte would be written at offset 0 of the boundary page, ovwPulse is raised once. No further byte of that frame is written, no header is written, and curPage keeps its value.
- R9: While monitorMode is high at a frame's first byte, the frame writes nothing, curPage keeps its value, and missedPulse is raised once for the frame.
- R10: curLoad has no effect while a frame is being received or its header is being written, or when a byte is offered in the same cycle.
- R11: During reset, curPage is 0 and memWe, ovwPulse and missedPulse are low.
- R12: Every write lands in a page within [ringStart, ringStop) and never in the boundary page. A write never happens in the same cycle as ovwPulse or missedPulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringStart | input | 8 | First page of the ring |
| ringStop | input | 8 | Page just past the ring |
| boundary | input | 8 | Host-owned page that must not be written |
| monitorMode | input | 1 | Count frames as missed instead of storing them |
| curLoad | input | 1 | Host load strobe for the current-page register |
| curLoadVal | input | 8 | Value for curLoad |
| rxValid | input | 1 | A frame byte is offered this cycle |
| rxData | input | 8 | Frame byte |
| rxLast | input | 1 | Marks the final byte of a frame |
| rxCrcErr | input | 1 | CRC error flag, sampled with the last byte |
| rxAlignErr | input | 1 | Alignment error flag, sampled with the last byte |
| rxMcast | input | 1 | Multicast/physical flag, sampled with the last byte |
| memWe | output | 1 | Buffer write strobe |
| memAddr | output | 16 | Buffer byte address |
| memData | output | 8 | Buffer write data |
| curPage | output | 8 | Current-page register |
| ovwPulse | output | 1 | Overwrite warning, one cycle per dropped frame |
| missedPulse | output | 1 | Missed-frame pulse in monitor mode |

## Verification
The assertions assume the following about the inputs:
- ringStart is below ringStop, and neither changes after reset.
- The boundary page lies inside the ring and changes only while no frame or header is in progress.
- curPage is loaded with a page inside the ring before the first frame.
- At least five cycles without rxValid follow every rxLast.

The stimulus sets the ring limits before reset is released and loads the current page while the block is idle. It changes the boundary or the mode only after an idle gap of eight cycles after the last byte. The one host load issued during a frame exercises the ignore rule of R10 and never points outside the ring.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_SKIP,
    ST_HDR,
    ST_COMMIT
  } rxState_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic       loadCur;
    logic       startFrame;
    logic       dataWr;
    logic       hdrWr;
    logic [1:0] hdrSel;
    logic       commit;
    logic       ovw;
    logic       missed;
  } ringStrobe_t;

endpackage

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
  import rxring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        monitorMode,
  input  logic        curLoad,
  input  logic        curAtBnd,
  input  logic        enterBnd,
  output ringStrobe_t strobe
);

  rxState_e state, nextState;
  logic [1:0] hdrCnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        strobe.loadCur = curLoad && !rxValid;
        if (rxValid) begin
          if (monitorMode) begin
            strobe.missed = 1'b1;
            nextState     = rxLast ? ST_IDLE : ST_SKIP;
          end else if (curAtBnd) begin
            strobe.ovw = 1'b1;
            nextState  = rxLast ? ST_IDLE : ST_SKIP;
          end else begin
            strobe.startFrame = 1'b1;
            nextState         = rxLast ? ST_HDR : ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (rxValid) begin
          if (enterBnd) begin
            strobe.ovw = 1'b1;
            nextState  = rxLast ? ST_IDLE : ST_SKIP;
          end else begin
            strobe.dataWr = 1'b1;
            nextState     = rxLast ? ST_HDR : ST_DATA;
          end
        end
      end
      ST_SKIP: begin
        if (rxValid && rxLast) nextState = ST_IDLE;
      end
      ST_HDR: begin
        strobe.hdrWr  = 1'b1;
        strobe.hdrSel = hdrCnt;
        if (hdrCnt == 2'd3) nextState = ST_COMMIT;
      end
      ST_COMMIT: begin
        strobe.commit = 1'b1;
        nextState     = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      hdrCnt <= 2'd0;
    end else begin
      state  <= nextState;
      hdrCnt <= (state == ST_HDR) ? hdrCnt + 2'd1 : 2'd0;
    end
  end

endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int PAGE_BYTES = 256,
  parameter int HDR_BYTES  = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ringStrobe_t           strobe,
  input  logic [PAGE_W-1:0]     ringStart,
  input  logic [PAGE_W-1:0]     ringStop,
  input  logic [PAGE_W-1:0]     boundary,
  input  logic [PAGE_W-1:0]     curLoadVal,
  input  logic [7:0]            rxData,
  input  logic                  rxLast,
  input  logic                  rxCrcErr,
  input  logic                  rxAlignErr,
  input  logic                  rxMcast,
  output logic                  curAtBnd,
  output logic                  enterBnd,
  output logic                  memWe,
  output logic [PAGE_W+$clog2(PAGE_BYTES)-1:0] memAddr,
  output logic [7:0]            memData,
  output logic [PAGE_W-1:0]     curPage,
  output logic                  ovwPulse,
  output logic                  missedPulse
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = 16;
  localparam logic [OFF_W-1:0] FIRST_OFF = OFF_W'(HDR_BYTES);

  logic [PAGE_W-1:0] wrPage;
  logic [OFF_W-1:0]  wrOff;
  logic [LEN_W-1:0]  lenCnt;
  logic              stCrc, stAlign, stMcast;
  logic [PAGE_W-1:0] nextPage;
  logic [7:0]        hdrByte;
  logic [7:0]        statusByte;

  function automatic logic [PAGE_W-1:0] stepPage(
    input logic [PAGE_W-1:0] p,
    input logic [PAGE_W-1:0] first,
    input logic [PAGE_W-1:0] limit
  );
    logic [PAGE_W-1:0] inc;
    inc = p + 1'b1;
    return (inc == limit) ? first : inc;
  endfunction

  assign curAtBnd = (curPage == boundary);
  assign enterBnd = (wrOff == '0) && (wrPage == boundary);
  // wrPage/wrOff address the byte to be written next
  assign nextPage = (wrOff == '0) ? wrPage : stepPage(wrPage, ringStart, ringStop);

  assign statusByte = {2'b00, stMcast, 2'b00, stAlign, stCrc, ~(stCrc | stAlign)};

  always_comb begin
    case (strobe.hdrSel)
      2'd0:    hdrByte = statusByte;
      2'd1:    hdrByte = 8'(nextPage);
      2'd2:    hdrByte = lenCnt[7:0];
      default: hdrByte = lenCnt[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage     <= '0;
      wrPage      <= '0;
      wrOff       <= '0;
      lenCnt      <= '0;
      stCrc       <= 1'b0;
      stAlign     <= 1'b0;
      stMcast     <= 1'b0;
      memWe       <= 1'b0;
      memAddr     <= '0;
      memData     <= '0;
      ovwPulse    <= 1'b0;
      missedPulse <= 1'b0;
    end else begin
      memWe       <= 1'b0;
      ovwPulse    <= strobe.ovw;
      missedPulse <= strobe.missed;
      if (strobe.loadCur) curPage <= curLoadVal;
      if (strobe.commit)  curPage <= nextPage;
      if ((strobe.startFrame || strobe.dataWr) && rxLast) begin
        stCrc   <= rxCrcErr;
        stAlign <= rxAlignErr;
        stMcast <= rxMcast;
      end
      if (strobe.startFrame) begin
        memWe   <= 1'b1;
        memAddr <= {curPage, FIRST_OFF};
        memData <= rxData;
        wrPage  <= curPage;
        wrOff   <= FIRST_OFF + 1'b1;
        lenCnt  <= LEN_W'(1);
      end
      if (strobe.dataWr) begin
        memWe   <= 1'b1;
        memAddr <= {wrPage, wrOff};
        memData <= rxData;
        wrOff   <= wrOff + 1'b1;
        lenCnt  <= lenCnt + 1'b1;
        if (wrOff == '1) wrPage <= stepPage(wrPage, ringStart, ringStop);
      end
      if (strobe.hdrWr) begin
        memWe   <= 1'b1;
        memAddr <= {curPage, OFF_W'(strobe.hdrSel)};
        memData <= hdrByte;
      end
    end
  end

endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int PAGE_W     = 8,
  parameter int PAGE_BYTES = 256,
  parameter int HDR_BYTES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] ringStart,
  input  logic [PAGE_W-1:0] ringStop,
  input  logic [PAGE_W-1:0] boundary,
  input  logic              monitorMode,
  input  logic              curLoad,
  input  logic [PAGE_W-1:0] curLoadVal,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxLast,
  input  logic              rxCrcErr,
  input  logic              rxAlignErr,
  input  logic              rxMcast,
  output logic              memWe,
  output logic [PAGE_W+$clog2(PAGE_BYTES)-1:0] memAddr,
  output logic [7:0]        memData,
  output logic [PAGE_W-1:0] curPage,
  output logic              ovwPulse,
  output logic              missedPulse
);

  ringStrobe_t strobe;
  logic curAtBnd, enterBnd;

  rxring_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .rxValid     (rxValid),
    .rxLast      (rxLast),
    .monitorMode (monitorMode),
    .curLoad     (curLoad),
    .curAtBnd    (curAtBnd),
    .enterBnd    (enterBnd),
    .strobe      (strobe)
  );

  rxring_dp #(
    .PAGE_W     (PAGE_W),
    .PAGE_BYTES (PAGE_BYTES),
    .HDR_BYTES  (HDR_BYTES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ringStart   (ringStart),
    .ringStop    (ringStop),
    .boundary    (boundary),
    .curLoadVal  (curLoadVal),
    .rxData      (rxData),
    .rxLast      (rxLast),
    .rxCrcErr    (rxCrcErr),
    .rxAlignErr  (rxAlignErr),
    .rxMcast     (rxMcast),
    .curAtBnd    (curAtBnd),
    .enterBnd    (enterBnd),
    .memWe       (memWe),
    .memAddr     (memAddr),
    .memData     (memData),
    .curPage     (curPage),
    .ovwPulse    (ovwPulse),
    .missedPulse (missedPulse)
  );

endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int PAGE_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [PAGE_W-1:0] ringStart,
  input logic [PAGE_W-1:0] ringStop,
  input logic [PAGE_W-1:0] boundary,
  input logic              curLoad,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PAGE_W-1:0] curPage,
  input logic              ovwPulse,
  input logic              missedPulse
);

  logic [PAGE_W-1:0] wrPg;
  assign wrPg = memAddr[ADDR_W-1 -: PAGE_W];

  // R12
  in_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (wrPg >= ringStart) && (wrPg < ringStop));

  // R12
  not_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (wrPg != boundary));

  // R7
  ovw_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovwPulse |-> !memWe);

  // R9
  missed_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    missedPulse |-> !memWe);

  // R6
  cur_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curPage != $past(curPage)) |-> ($past(curLoad) || $past(memWe)));

  // R8
  ovw_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovwPulse |=> !ovwPulse);

  // R11
  always_comb begin
    if (!rstN) begin
      reset_quiet_chk: assert (!(memWe && $isunknown(memAddr)));
    end
  end

endmodule

bind rxring_writer rxring_chk #(
  .PAGE_W (PAGE_W),
  .ADDR_W (PAGE_W + $clog2(PAGE_BYTES))
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .ringStart   (ringStart),
  .ringStop    (ringStop),
  .boundary    (boundary),
  .curLoad     (curLoad),
  .memWe       (memWe),
  .memAddr     (memAddr),
  .curPage     (curPage),
  .ovwPulse    (ovwPulse),
  .missedPulse (missedPulse)
);

// File: tb/rxring_writer_tb_top.sv
`timescale 1ns/1ps
module rxring_writer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ringStart = 8'h40;
  logic [7:0]  ringStop  = 8'h46;
  logic [7:0]  boundary  = 8'h45;
  logic        monitorMode = 1'b0;
  logic        curLoad = 1'b0;
  logic [7:0]  curLoadVal = 8'h00;
  logic        rxValid = 1'b0;
  logic [7:0]  rxData = 8'h00;
  logic        rxLast = 1'b0;
  logic        rxCrcErr = 1'b0;
  logic        rxAlignErr = 1'b0;
  logic        rxMcast = 1'b0;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData;
  logic [7:0]  curPage;
  logic        ovwPulse;
  logic        missedPulse;

  always #4 clk = ~clk;

  rxring_writer dut_i (
    .clk(clk), .rstN(rstN), .ringStart(ringStart), .ringStop(ringStop),
    .boundary(boundary), .monitorMode(monitorMode), .curLoad(curLoad),
    .curLoadVal(curLoadVal), .rxValid(rxValid), .rxData(rxData),
    .rxLast(rxLast), .rxCrcErr(rxCrcErr), .rxAlignErr(rxAlignErr),
    .rxMcast(rxMcast), .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .curPage(curPage), .ovwPulse(ovwPulse), .missedPulse(missedPulse)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;
  string wrTag = "R1";
  logic [23:0] expQ[$];
  int ovwSeen = 0, missedSeen = 0, expOvw = 0, expMissed = 0;
  logic [7:0] mCur = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (monOn) begin
      if (ovwPulse) ovwSeen++;
      if (missedPulse) missedSeen++;
      if (memWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, wrTag, int'({memAddr, memData}), 0);
        end else begin
          logic [23:0] e;
          e = expQ.pop_front();
          check({memAddr, memData} == e, wrTag, int'({memAddr, memData}), int'(e));
        end
      end
    end
  end

  function automatic logic [7:0] step(input logic [7:0] p);
    return (p + 8'd1 == ringStop) ? ringStart : p + 8'd1;
  endfunction

  task automatic loadCur(input logic [7:0] v);
    @(negedge clk);
    curLoad = 1'b1; curLoadVal = v;
    @(negedge clk);
    curLoad = 1'b0;
    mCur = v;
    check(curPage == v, "R6 load", int'(curPage), int'(v));
  endtask

  task automatic sendFrame(input int len, input bit crc, input bit aln, input bit mc,
                           input int seed, input int loadAt, input logic [7:0] loadVal,
                           input string tag);
    logic [7:0] page;
    int off;
    bit drop;
    wrTag = tag;
    // expected model
    if (monitorMode) expMissed++;
    else if (mCur == boundary) expOvw++;
    else begin
      page = mCur; off = 4; drop = 1'b0;
      for (int i = 0; i < len; i++) begin
        if (i > 0 && off == 0 && page == boundary) begin
          drop = 1'b1; expOvw++; break;
        end
        expQ.push_back({page, 8'(off), 8'(i * 7 + seed)});
        off++;
        if (off == 256) begin off = 0; page = step(page); end
      end
      if (!drop) begin
        logic [7:0] nxt;
        nxt = (off == 0) ? page : step(page);
        expQ.push_back({mCur, 8'd0, 2'b00, mc, 2'b00, aln, crc, ~(crc | aln)});
        expQ.push_back({mCur, 8'd1, nxt});
        expQ.push_back({mCur, 8'd2, 8'(len)});
        expQ.push_back({mCur, 8'd3, 8'(len >> 8)});
        mCur = nxt;
      end
    end
    // drive
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = 8'(i * 7 + seed); rxLast = (i == len - 1);
      rxCrcErr = crc; rxAlignErr = aln; rxMcast = mc;
      curLoad = (i == loadAt); curLoadVal = loadVal;
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0; curLoad = 1'b0;
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, {tag, " R3 writes"}, expQ.size(), 0);
    check(curPage == mCur, {tag, " R6 curPage"}, int'(curPage), int'(mCur));
    check(ovwSeen == expOvw, {tag, " ovw count"}, ovwSeen, expOvw);
    check(missedSeen == expMissed, {tag, " missed count"}, missedSeen, expMissed);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(curPage == 8'h00, "R11 curPage", int'(curPage), 0);
    check(!memWe && !ovwPulse && !missedPulse, "R11 outputs", int'({memWe, ovwPulse, missedPulse}), 0);
    rstN = 1'b1;
    monOn = 1'b1;
    loadCur(8'h40);
    sendFrame(64, 0, 0, 0, 3, -1, 8'h00, "R1");        // next 0x41
    sendFrame(300, 1, 0, 1, 11, -1, 8'h00, "R4 crc"); // spans 2 pages, next 0x43
    sendFrame(252, 0, 1, 0, 5, -1, 8'h00, "R5 fit");  // ends at 0x43FF, next 0x44
    check(curPage == 8'h44, "R5 exact page fit", int'(curPage), 8'h44);
    boundary = 8'h43;
    sendFrame(600, 0, 0, 0, 9, -1, 8'h00, "R2 wrap"); // 0x44,0x45,0x40 -> next 0x41
    check(curPage == 8'h41, "R2 wrap next", int'(curPage), 8'h41);
    sendFrame(700, 0, 0, 0, 1, -1, 8'h00, "R8 mid");  // hits 0x43, dropped
    check(curPage == 8'h41, "R8 cur kept", int'(curPage), 8'h41);
    boundary = 8'h41;
    sendFrame(40, 0, 0, 0, 2, -1, 8'h00, "R7 start");
    boundary = 8'h40;
    monitorMode = 1'b1;
    repeat (2) @(negedge clk);
    sendFrame(30, 0, 0, 0, 4, -1, 8'h00, "R9 monitor");
    monitorMode = 1'b0;
    repeat (2) @(negedge clk);
    sendFrame(20, 0, 0, 1, 6, 5, 8'h45, "R10 load");   // load ignored, next 0x42
    check(curPage == 8'h42, "R10 cur", int'(curPage), 8'h42);
    sendFrame(1, 1, 1, 0, 8, -1, 8'h00, "R3 single");  // next 0x43
    boundary = 8'h44;
    loadCur(8'h45);
    sendFrame(60, 0, 0, 0, 12, -1, 8'h00, "R5 hdr wrap"); // next 0x40
    check(curPage == 8'h40, "R5 wrap to start", int'(curPage), 8'h40);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule